// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. It frees the bus after a transfer was cut short, after power loss or after a reset. On a one-cycle request it plays a fixed recovery pattern on the two open-drain lines and then reports completion. The pattern has four parts:

- a start condition;
- a train of dummy clock pulses with the data line left released;
- a second start condition;
- a stop condition.

A slave that was stalled in the middle of a byte either shifts out its remaining bits or sees the new start, and the final stop returns every device to its idle state.

The block never drives a line high. Each line has a pull-enable output, and the pad outside turns that into an open-drain driver. A `1` on an enable pulls the line low and a `0` releases it to the external pull-up. Every phase of the pattern lasts one half-period of `HALF_CYC` system clocks. The length of the dummy clock train is set by `NUM_PULSES`, which defaults to nine.

The controller is one Moore state machine whose states each last one half-period:

| State | SCL | SDA | Leaves when | Goes to |
|---|---|---|---|---|
| IDLE | released | released | request | PRE |
| PRE | released | released | half-period ends | START1 |
| START1 | released | pulled (data falls) | half-period ends | HOLD |
| HOLD | pulled | pulled | half-period ends | CLK_LOW |
| CLK_LOW | pulled | released | half-period ends | CLK_HIGH |
| CLK_HIGH | released | released | half-period ends | CLK_LOW while pulses remain, START2 after the last pulse |
| START2 | released | pulled (data falls) | half-period ends | STOP_LOW |
| STOP_LOW | pulled | pulled | half-period ends | STOP_HIGH |
| STOP_HIGH | released (clock rises) | pulled | half-period ends | STOP_REL |
| STOP_REL | released | released (data rises) | half-period ends | DONE |
| DONE | released | released | always, after one cycle | IDLE |

Top module: `bus_recover_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, scl_pull_o, sda_pull_o, busy_o and done_o are all 0.
- R2: Whenever busy_o is 0, both pull enables are 0. After a request is accepted, both lines stay released for exactly HALF_CYC cycles before anything else happens.
- R3: The first start condition is SDA being pulled low while SCL is released, HALF_CYC cycles after busy_o rises. The two pull enables never change in the same cycle.
- R4: Exactly NUM_PULSES (default 9) SCL rising edges occur between the two start conditions, and SDA stays released during every one of them.
- R5: Dummy pulse k (k = 1..NUM_PULSES) rises 4*HALF_CYC + 2*HALF_CYC*(k-1) cycles after busy_o rises, so each pulse has a period of 2*HALF_CYC.
- R6: The second start (SDA pulled low, SCL released) happens HALF_CYC cycles after the last dummy rise. SCL is then pulled low. SCL rises with SDA still low at 23*HALF_CYC, and SDA is released one half-period later, at 24*HALF_CYC. All times are counted from the rise of busy_o.
- R7: done_o is a one-cycle pulse at 25*HALF_CYC cycles after busy_o rises. In the next cycle the block is idle.
- R8: busy_o rises in the cycle after a request is sampled. It stays high up to and including the done_o cycle, for 25*HALF_CYC+1 cycles in all. A request that arrives while busy_o is high, including in the done_o cycle, changes no timing and does not start another sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request to start the recovery pattern |
| scl_pull_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| busy_o | output | 1 | High while a pattern is in progress |
| done_o | output | 1 | One-cycle pulse when the pattern is complete |

## Verification
A new request and the completion of a pattern can fall in the same cycle. The bench provokes this by pulsing req_i exactly in the cycle where done_o is sampled high. It then confirms that busy_o falls and that both lines stay released for several half-periods afterwards, so no new pattern starts. A second collision is provoked by a request in the middle of the clock train. It is judged by the scoreboard: every expected event must keep its exact cycle offset from the rise of busy_o.

// File: rtl/recov_pkg.sv
package recov_pkg;

    // Each state lasts one half-period, except DONE, which lasts one cycle.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_START1,
        ST_HOLD,
        ST_CLK_LOW,
        ST_CLK_HIGH,
        ST_START2,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_STOP_REL,
        ST_DONE
    } recov_state_t;

    // Pull-enable pair driven toward the pads (1 pulls the line low).
    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
    } line_pull_t;

endpackage

// File: rtl/recov_half_timer.sv
// Half-period timer. It restarts whenever run_i is low and raises tick_o
// on the last cycle of each half-period while running.
module recov_half_timer #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/recov_pulse_count.sv
// Counts the completed dummy clock high phases and flags the final one.
module recov_pulse_count #(
    parameter int NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output logic last_o
);
    localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
    localparam logic [PW-1:0] FINAL = PW'(NUM_PULSES - 1);

    logic [PW-1:0] cnt_q;

    assign last_o = (cnt_q == FINAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (step_i && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bus_recover_seq.sv
// Two-wire bus recovery sequencer: start, dummy clock train, start, stop.
module bus_recover_seq
    import recov_pkg::*;
#(
    parameter int HALF_CYC   = 8,
    parameter int NUM_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic busy_o,
    output logic done_o
);
    recov_state_t st_q, st_d;
    line_pull_t   pull;
    logic         run;
    logic         tick;
    logic         last_pulse;
    logic         pulse_step;
    logic         pulse_clr;

    // The timer runs in every state that lasts a half-period.
    assign run        = (st_q != ST_IDLE) && (st_q != ST_DONE);
    assign pulse_step = tick && (st_q == ST_CLK_HIGH);
    assign pulse_clr  = (st_q == ST_IDLE);

    recov_half_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    recov_pulse_count #(.NUM_PULSES(NUM_PULSES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (pulse_clr),
        .step_i (pulse_step),
        .last_o (last_pulse)
    );

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (req_i) st_d = ST_PRE;
            ST_PRE:       if (tick)  st_d = ST_START1;
            ST_START1:    if (tick)  st_d = ST_HOLD;
            ST_HOLD:      if (tick)  st_d = ST_CLK_LOW;
            ST_CLK_LOW:   if (tick)  st_d = ST_CLK_HIGH;
            ST_CLK_HIGH:  if (tick)  st_d = last_pulse ? ST_START2 : ST_CLK_LOW;
            ST_START2:    if (tick)  st_d = ST_STOP_LOW;
            ST_STOP_LOW:  if (tick)  st_d = ST_STOP_HIGH;
            ST_STOP_HIGH: if (tick)  st_d = ST_STOP_REL;
            ST_STOP_REL:  if (tick)  st_d = ST_DONE;
            ST_DONE:                 st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Moore outputs: line pulls and flags follow the state alone.
    always_comb begin
        pull   = '{scl_pull: 1'b0, sda_pull: 1'b0};
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (st_q)
            ST_IDLE:      busy_o = 1'b0;
            ST_PRE:       ;
            ST_START1:    pull.sda_pull = 1'b1;
            ST_HOLD:      pull = '{scl_pull: 1'b1, sda_pull: 1'b1};
            ST_CLK_LOW:   pull.scl_pull = 1'b1;
            ST_CLK_HIGH:  ;
            ST_START2:    pull.sda_pull = 1'b1;
            ST_STOP_LOW:  pull = '{scl_pull: 1'b1, sda_pull: 1'b1};
            ST_STOP_HIGH: pull.sda_pull = 1'b1;
            ST_STOP_REL:  ;
            ST_DONE:      done_o = 1'b1;
            default:      busy_o = 1'b0;
        endcase
    end

    assign scl_pull_o = pull.scl_pull;
    assign sda_pull_o = pull.sda_pull;
endmodule

// File: rtl/recov_checker.sv
// Protocol checker attached to every instance of the sequencer.
module recov_checker (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic scl_pull_o,
    input logic sda_pull_o,
    input logic busy_o,
    input logic done_o
);
    // R2: an idle block releases both lines.
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_pull_o && !sda_pull_o));

    // R3: the two lines never move in the same cycle.
    a_r3_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_pull_o) |-> $stable(sda_pull_o));

    // R6: once SDA is released with SCL high (the stop), the bus stays released.
    a_r6_stop_stays_released: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_pull_o) && !scl_pull_o) |=> (!scl_pull_o && !sda_pull_o));

    // R7: done lasts one cycle and is followed by idle.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R8: a request from idle makes the block busy in the next cycle.
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !busy_o) |=> busy_o);

    // R8: busy stays high until the done cycle, whatever the request does.
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R7: done is never raised outside a sequence.
    always_comb begin
        if (rst_n) begin
            a_r7_done_in_busy: assert (!done_o || busy_o);
        end
    end
endmodule

bind bus_recover_seq recov_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/sim_bus_recover_seq.sv
`timescale 1ns/1ps
module sim_bus_recover_seq;
    localparam int H  = 4;
    localparam int NP = 9;

    localparam int EV_START = 1;
    localparam int EV_RISE  = 2;
    localparam int EV_STOP  = 3;
    localparam int EV_DONE  = 4;

    typedef struct packed {
        logic [31:0] code;
        logic [31:0] ofs;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_i = 1'b0;
    logic scl_pull_o, sda_pull_o, busy_o, done_o;

    int total = 0;
    int bad = 0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bus_recover_seq #(.HALF_CYC(H), .NUM_PULSES(NP)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .scl_pull_o (scl_pull_o),
        .sda_pull_o (sda_pull_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string ev_tag(input int code, input int starts);
        if (code == EV_START) return (starts == 0) ? "R3 first start" : "R6 second start";
        if (code == EV_RISE)  return (starts < 2) ? "R5 dummy rise" : "R6 stop rise";
        if (code == EV_STOP)  return "R6 stop";
        return "R7 done";
    endfunction

    // Driver: pushes the expected events of one pattern into the scoreboard.
    task automatic push_expected();
        sb_q.push_back('{code: EV_START, ofs: H});
        for (int k = 1; k <= NP; k++)
            sb_q.push_back('{code: EV_RISE, ofs: 4*H + 2*H*(k-1)});
        sb_q.push_back('{code: EV_START, ofs: 21*H});
        sb_q.push_back('{code: EV_RISE,  ofs: 23*H});
        sb_q.push_back('{code: EV_STOP,  ofs: 24*H});
        sb_q.push_back('{code: EV_DONE,  ofs: 25*H});
    endtask

    // Driver: requests one pattern, optionally with requests that must be ignored.
    task automatic run_pattern(input bit poke);
        push_expected();
        @(negedge clk); req_i = 1'b1;
        @(negedge clk); req_i = 1'b0;
        check("R8 busy after request", int'(busy_o), 1);
        if (poke) begin
            repeat (7*H) @(negedge clk);
            req_i = 1'b1;
            @(negedge clk); req_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        if (poke) begin
            req_i = 1'b1;
            @(negedge clk); req_i = 1'b0;
        end else begin
            @(negedge clk);
        end
        repeat (3*H) @(negedge clk);
        check("R8 ignored request left idle busy", int'(busy_o), 0);
        check("R2 idle scl released", int'(scl_pull_o), 0);
        check("R2 idle sda released", int'(sda_pull_o), 0);
    endtask

    // Monitor: turns line activity into events and compares them with the scoreboard.
    int   cyc = 0;
    int   busy_t = 0;
    int   starts = 0;
    int   rises_between = 0;
    logic scl_q = 1'b1, sda_q = 1'b1, busy_q = 1'b0;

    task automatic take_event(input int code);
        exp_t e;
        if (sb_q.size() == 0) begin
            total++; bad++;
            $display("FAIL %s actual=unexpected event %0d expected=none", ev_tag(code, starts), code);
            return;
        end
        e = sb_q.pop_front();
        check(ev_tag(code, starts), code, int'(e.code));
        check(ev_tag(code, starts), cyc - busy_t, int'(e.ofs));
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic scl, sda;
            cyc++;
            scl = !scl_pull_o;
            sda = !sda_pull_o;
            if (busy_o && !busy_q) begin
                busy_t = cyc;
                starts = 0;
                rises_between = 0;
            end
            if (scl && scl_q && sda_q && !sda) begin
                if (starts == 1)
                    check("R4 rises between starts", rises_between, NP);
                take_event(EV_START);
                starts++;
            end
            if (scl && !scl_q) begin
                if (starts == 1) begin
                    rises_between++;
                    check("R4 sda released at dummy rise", int'(sda), 1);
                end
                take_event(EV_RISE);
            end
            if (scl && scl_q && !sda_q && sda)
                take_event(EV_STOP);
            if (done_o)
                take_event(EV_DONE);
            if (!busy_o && busy_q)
                check("R8 busy length", cyc - busy_t, 25*H + 1);
            scl_q  = scl;
            sda_q  = sda;
            busy_q = busy_o;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 scl in reset", int'(scl_pull_o), 0);
        check("R1 sda in reset", int'(sda_pull_o), 0);
        check("R1 busy in reset", int'(busy_o), 0);
        check("R1 done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy_o), 0);
        check("R2 released after reset", int'(scl_pull_o | sda_pull_o), 0);
        run_pattern(1'b0);
        run_pattern(1'b1);
        run_pattern(1'b0);
        check("R7 scoreboard drained", sb_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule